// File: doc/BRIEF.md
# Stream Error Flush-and-Reset Controller

This block sits on a valid/ready stream between a data source and a reconfiguration engine that reports a 3-bit status. While the engine is healthy the block adds nothing: valid, data and ready pass straight through, with no register on the path. When the engine flags a stream fault, the engine stops accepting data and the source would otherwise stall mid-stream with the rest of a corrupt image still queued.

On a fault the block takes over the handshake. It drives ready high toward the source so the leftover words drain, and it discards those words instead of forwarding them. Once the source's valid has been quiet for a set number of consecutive cycles, it pulses a synchronous reset into the engine. It then waits for the fault status to clear and returns to pass-through, so the next stream reaches the engine complete from its first word. If the status stays in fault too long after a reset, the reset is issued again.

Top module: `stream_err_recover`

## Requirements
- R1: While idle (`recovering` low), `src_ready` equals `eng_ready`, and `eng_valid`/`eng_data` equal `src_valid`/`src_data`, combinationally in the same cycle.
- R2: A status of 3'b100 on `eng_status`, seen at a clock edge while idle, makes `recovering` high from the next cycle. Any other code leaves the block idle.
- R3: While flushing, `src_ready` is high and `eng_valid` is low, so every upstream word is accepted and none is forwarded.
- R4: The flush ends only after `src_valid` has been low for QUIET_CYCLES (default 16) consecutive cycles. Any cycle with `src_valid` high restarts that count. The first flush cycle counts as a low cycle when `src_valid` is low.
- R5: `eng_reset` is active high and goes high only when the flush ends. It then stays high for exactly RESET_CYCLES (default 4) cycles, and it never rises while idle.
- R6: After `eng_reset` falls, the block stays recovering until a clock edge sees the status differ from 3'b100. It then returns to idle on the next cycle, and `recovering` is high in every non-idle state.
- R7: If the status is still 3'b100 after CLEAR_TIMEOUT (default 64) cycles of waiting, `eng_reset` is pulsed again.
- R8: `rst_n` low at a clock edge puts the block back in the idle state, drops `eng_reset` and clears all counters, so the next flush needs a full quiet window.
- R9: Outside the flush and outside idle, `src_ready` is low. The source therefore holds its next stream, which reaches the engine intact from its first word once the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Upstream word valid |
| src_data | input | DATA_W | Upstream word |
| src_ready | output | 1 | Ready toward the source (passed through, or substituted during a flush) |
| eng_valid | output | 1 | Valid toward the engine |
| eng_data | output | DATA_W | Word toward the engine |
| eng_ready | input | 1 | Ready from the engine |
| eng_status | input | 3 | Engine status; 3'b100 means a stream fault |
| eng_reset | output | 1 | Active-high synchronous reset pulse to the engine |
| recovering | output | 1 | High in every state except pass-through |

## Verification
The fault is injected under several upstream valid patterns during the flush:
- a source that is already quiet, which gives the minimum flush;
- a burst that ends and then goes quiet, which gives a flush of burst length plus the window;
- a gap of one cycle short of the window followed by a further word, which shows that the quiet count restarts rather than accumulating.

A scoreboard holds the words sent while idle. Any flushed word that leaked to the engine, or any word lost from the stream after recovery, shows up as a miscompare. Non-fault status codes, an engine that stays in fault past the timeout, and a reset arriving mid-pulse separate the ignored case, the re-reset path and the counter clearing.

// File: rtl/err_rec_pkg.sv
// Shared types for the stream error recovery controller.
// Assumes a 3-bit engine status in which one code marks a stream fault.
package err_rec_pkg;
    localparam int STATUS_W = 3;
    localparam logic [STATUS_W-1:0] STATUS_FAULT = 3'b100;

    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_RESET = 2'd2,
        ST_WAIT  = 2'd3
    } rec_state_e;
endpackage

// File: rtl/err_rec_counter.sv
// Run-length counter: counts 'step' cycles up to LIMIT and flags the last one.
// Assumes 'clear' has priority over 'step'; wraps to zero on the terminal step.
module err_rec_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Terminal step: this step reaches the limit.
    always_comb done = step && !clear && (cnt == LAST);

    // Count steps, restart on clear or after the terminal step.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (clear)    cnt <= '0;
        else if (done)     cnt <= '0;
        else if (step)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/err_rec_fsm.sv
// Recovery sequencer: pass-through, flush, engine reset, wait for status clear.
// Assumes counters report their terminal step combinationally via *_done.
module err_rec_fsm
    import err_rec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       status_fault,
    input  logic       src_valid,
    input  logic       quiet_done,
    input  logic       hold_done,
    input  logic       wait_done,
    output rec_state_e state,
    output logic       quiet_clr,
    output logic       quiet_step,
    output logic       hold_clr,
    output logic       hold_step,
    output logic       wait_clr,
    output logic       wait_step
);
    rec_state_e state_nxt;

    // Counter controls derived from the current state.
    always_comb begin
        quiet_step = (state == ST_FLUSH) && !src_valid;
        quiet_clr  = (state != ST_FLUSH) || src_valid;
        hold_step  = (state == ST_RESET);
        hold_clr   = (state != ST_RESET);
        wait_step  = (state == ST_WAIT) && status_fault;
        wait_clr   = (state != ST_WAIT);
    end

    // Next-state selection.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_PASS:  if (status_fault) state_nxt = ST_FLUSH;
            ST_FLUSH: if (quiet_done)   state_nxt = ST_RESET;
            ST_RESET: if (hold_done)    state_nxt = ST_WAIT;
            ST_WAIT: begin
                if (!status_fault)      state_nxt = ST_PASS;
                else if (wait_done)     state_nxt = ST_RESET;
            end
            default:                    state_nxt = ST_PASS;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PASS;
        else        state <= state_nxt;
    end
endmodule

// File: rtl/err_rec_path.sv
// Handshake steering: forwards the stream in pass-through, swallows it in flush,
// stalls the source otherwise. Purely combinational, adds no latency.
module err_rec_path
    import err_rec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rec_state_e        state,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              eng_ready,
    output logic              src_ready,
    output logic              eng_valid,
    output logic [DATA_W-1:0] eng_data
);
    logic pass;

    // Select pass-through, substitute ready, or stall.
    always_comb begin
        pass      = (state == ST_PASS);
        src_ready = pass ? eng_ready : (state == ST_FLUSH);
        eng_valid = pass && src_valid;
        eng_data  = pass ? src_data : '0;
    end
endmodule

// File: rtl/stream_err_recover.sv
// Top: watches engine status, drains a faulted stream, resets the engine,
// and returns to pass-through. Assumes engine status is synchronous to clk.
module stream_err_recover
    import err_rec_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int QUIET_CYCLES  = 16,
    parameter int RESET_CYCLES  = 4,
    parameter int CLEAR_TIMEOUT = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_valid,
    input  logic [DATA_W-1:0]   src_data,
    output logic                src_ready,
    output logic                eng_valid,
    output logic [DATA_W-1:0]   eng_data,
    input  logic                eng_ready,
    input  logic [STATUS_W-1:0] eng_status,
    output logic                eng_reset,
    output logic                recovering
);
    rec_state_e state;
    logic status_fault;
    logic quiet_clr, quiet_step, quiet_done;
    logic hold_clr, hold_step, hold_done;
    logic wait_clr, wait_step, wait_done;

    // Fault decode and state-derived outputs.
    always_comb begin
        status_fault = (eng_status == STATUS_FAULT);
        eng_reset    = (state == ST_RESET);
        recovering   = (state != ST_PASS);
    end

    err_rec_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .status_fault(status_fault), .src_valid(src_valid),
        .quiet_done(quiet_done), .hold_done(hold_done), .wait_done(wait_done),
        .state(state), .quiet_clr(quiet_clr), .quiet_step(quiet_step),
        .hold_clr(hold_clr), .hold_step(hold_step),
        .wait_clr(wait_clr), .wait_step(wait_step)
    );

    err_rec_counter #(.LIMIT(QUIET_CYCLES)) u_quiet (
        .clk(clk), .rst_n(rst_n), .clear(quiet_clr), .step(quiet_step), .done(quiet_done)
    );

    err_rec_counter #(.LIMIT(RESET_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .clear(hold_clr), .step(hold_step), .done(hold_done)
    );

    err_rec_counter #(.LIMIT(CLEAR_TIMEOUT)) u_wait (
        .clk(clk), .rst_n(rst_n), .clear(wait_clr), .step(wait_step), .done(wait_done)
    );

    err_rec_path #(.DATA_W(DATA_W)) u_path (
        .state(state), .src_valid(src_valid), .src_data(src_data), .eng_ready(eng_ready),
        .src_ready(src_ready), .eng_valid(eng_valid), .eng_data(eng_data)
    );
endmodule

// File: rtl/err_rec_checker.sv
// Port-level protocol checks for stream_err_recover, bound to every instance.
// Assumes the synchronous active-low reset of the design.
module err_rec_checker #(
    parameter int DATA_W        = 8,
    parameter int QUIET_CYCLES  = 16,
    parameter int RESET_CYCLES  = 4,
    parameter int CLEAR_TIMEOUT = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_valid,
    input logic [DATA_W-1:0] src_data,
    input logic              src_ready,
    input logic              eng_valid,
    input logic [DATA_W-1:0] eng_data,
    input logic              eng_ready,
    input logic [2:0]        eng_status,
    input logic              eng_reset,
    input logic              recovering
);
    logic [31:0] quiet_run;
    logic [31:0] pulse_run;
    logic [31:0] wait_run;
    logic        waiting;

    always_comb waiting = recovering && !eng_reset && !src_ready;

    // Observed run lengths: quiet source, reset pulse, waiting for status clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_run <= '0;
            pulse_run <= '0;
            wait_run  <= '0;
        end else begin
            quiet_run <= src_valid ? '0 : ((quiet_run < 32'(QUIET_CYCLES)) ? quiet_run + 1 : quiet_run);
            pulse_run <= eng_reset ? pulse_run + 1 : '0;
            wait_run  <= waiting   ? wait_run + 1  : '0;
        end
    end

    assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !recovering |-> (src_ready == eng_ready && eng_valid == src_valid && eng_data == src_data));

    assert_fault_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!recovering && eng_status == 3'b100) |=> recovering);

    assert_other_codes_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!recovering && eng_status != 3'b100) |=> !recovering);

    assert_no_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
        recovering |-> !eng_valid);

    assert_quiet_before_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_reset) |-> (quiet_run >= 32'(QUIET_CYCLES)));

    assert_pulse_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_reset) |-> (pulse_run == 32'(RESET_CYCLES)));

    assert_reset_only_recovering_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> recovering);

    assert_clear_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && eng_status != 3'b100) |=> !recovering);

    assert_wait_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_run <= 32'(CLEAR_TIMEOUT));

    assert_reset_idle_R8: assert property (@(posedge clk)
        !rst_n |=> (!eng_reset && !recovering));

    assert_stall_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> !src_ready);
endmodule

bind stream_err_recover err_rec_checker #(
    .DATA_W(DATA_W), .QUIET_CYCLES(QUIET_CYCLES),
    .RESET_CYCLES(RESET_CYCLES), .CLEAR_TIMEOUT(CLEAR_TIMEOUT)
) u_checker (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .eng_valid(eng_valid), .eng_data(eng_data),
    .eng_ready(eng_ready), .eng_status(eng_status), .eng_reset(eng_reset),
    .recovering(recovering)
);

// File: tb/tb_stream_err_recover.sv
// Scoreboard bench: driver pushes words expected at the engine, monitor pops them.
module tb_stream_err_recover;
    localparam int DW    = 8;
    localparam int QUIET = 16;
    localparam int RSTC  = 4;
    localparam int TMO   = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_ready, eng_valid, eng_reset, recovering;
    logic [DW-1:0] eng_data;
    logic          eng_ready;
    logic [2:0]    eng_status;

    logic       eng_err = 1'b0;
    logic       inject_req = 1'b0;
    logic       stuck = 1'b0;
    logic       ready_en = 1'b1;
    logic [2:0] idle_code = 3'b000;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;
    logic [DW-1:0] expq[$];

    always #10 clk = ~clk;

    // Engine model: faults on request, clears when reset (unless held stuck).
    always @(posedge clk) begin
        if (!rst_n)                    eng_err <= 1'b0;
        else if (inject_req)           eng_err <= 1'b1;
        else if (eng_reset && !stuck)  eng_err <= 1'b0;
    end
    assign eng_status = eng_err ? 3'b100 : idle_code;
    assign eng_ready  = !eng_err && ready_en;

    stream_err_recover #(.DATA_W(DW), .QUIET_CYCLES(QUIET), .RESET_CYCLES(RSTC),
                         .CLEAR_TIMEOUT(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .eng_valid(eng_valid), .eng_data(eng_data),
        .eng_ready(eng_ready), .eng_status(eng_status), .eng_reset(eng_reset),
        .recovering(recovering)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: every word the engine accepts must be the next expected one.
    initial begin
        forever begin
            @(negedge clk); #8;
            if (rst_n && eng_valid && eng_ready) begin
                if (expq.size() == 0) chk(0, "R3 unexpected word at engine", int'(eng_data), -1);
                else begin
                    logic [DW-1:0] e;
                    e = expq.pop_front();
                    chk(eng_data == e, "R9 scoreboard word", int'(eng_data), int'(e));
                end
            end
        end
    end

    task automatic step_cycle();
        @(negedge clk); #8;
    endtask

    // Driver: send one word in pass-through, expecting it at the engine.
    task automatic send_word(input logic [DW-1:0] d);
        bit acc;
        @(negedge clk);
        src_valid = 1'b1; src_data = d;
        expq.push_back(d);
        acc = 0;
        while (!acc) begin
            #8; acc = src_ready;
            @(negedge clk);
        end
        src_valid = 1'b0;
    endtask

    // Inject a fault; check entry timing; run a flush with a valid pattern.
    // Pattern: flush cycle k valid when 1<=k<=h1 or h1+l1<k<=h1+l1+h2.
    task automatic fault_and_flush(input int h1, input int l1, input int h2,
                                   input int exp_len, output int flen);
        int k; int words;
        @(negedge clk); src_valid = 1'b0; inject_req = 1'b1;
        #8;
        @(negedge clk); inject_req = 1'b0; #8;
        chk(!recovering && !src_ready, "R2 engine fault seen, still idle", int'(recovering), 0);
        step_cycle();
        chk(recovering, "R2 fault code starts recovery", int'(recovering), 1);
        k = 0; flen = 0; words = 0;
        while (!eng_reset && flen < 1000) begin
            flen++;
            if (src_valid) begin
                words++;
                chk(src_ready && !eng_valid, "R3 flush accepts and drops", int'(src_ready), 1);
            end
            k++;
            @(negedge clk);
            src_valid = ((k >= 1 && k <= h1) || (k > h1 + l1 && k <= h1 + l1 + h2));
            src_data  = DW'(8'hA0 + k);
            #8;
        end
        src_valid = 1'b0;
        chk(flen == exp_len, "R4 flush length", flen, exp_len);
        chk(words == h1 + h2, "R3 flushed word count", words, h1 + h2);
    endtask

    // Measure one reset pulse from its first high sample.
    task automatic measure_pulse(output int rlen);
        rlen = 0;
        while (eng_reset && rlen < 100) begin
            rlen++;
            if (!src_ready) ; else chk(0, "R9 source stalled during reset", 1, 0);
            step_cycle();
        end
    endtask

    task automatic normal_recovery(input int h1, input int l1, input int h2, input int exp_len);
        int flen; int rlen;
        fault_and_flush(h1, l1, h2, exp_len, flen);
        measure_pulse(rlen);
        chk(rlen == RSTC, "R5 reset pulse length", rlen, RSTC);
        chk(recovering && !src_ready, "R6 waiting after reset", int'(recovering), 1);
        step_cycle();
        chk(!recovering, "R6 back to idle once status clears", int'(recovering), 0);
    endtask

    initial begin
        int flen; int rlen; int gap;
        repeat (3) @(negedge clk);
        #8;
        chk(!eng_reset && !recovering, "R8 reset state", int'(recovering), 0);
        chk(src_ready == eng_ready, "R8 reset state ready", int'(src_ready), int'(eng_ready));
        @(negedge clk); rst_n = 1'b1;

        // R1: combinational pass-through in the same cycle.
        @(negedge clk); src_valid = 1'b1; src_data = 8'h5C; ready_en = 1'b0; #8;
        chk(eng_valid && eng_data == 8'h5C, "R1 valid/data pass", int'(eng_data), 8'h5C);
        chk(src_ready == 1'b0, "R1 ready pass low", int'(src_ready), 0);
        @(negedge clk); src_valid = 1'b0; ready_en = 1'b1; #8;
        chk(src_ready && !eng_valid, "R1 ready pass high", int'(src_ready), 1);

        // Baseline traffic through the scoreboard.
        for (int i = 0; i < 6; i++) send_word(DW'(8'h10 + i));

        // R2: non-fault codes are ignored.
        idle_code = 3'b010; step_cycle(); step_cycle();
        chk(!recovering, "R2 code 010 ignored", int'(recovering), 0);
        idle_code = 3'b111; step_cycle(); step_cycle();
        chk(!recovering, "R2 code 111 ignored", int'(recovering), 0);
        idle_code = 3'b101; step_cycle(); step_cycle();
        chk(!recovering, "R2 code 101 ignored", int'(recovering), 0);
        idle_code = 3'b000;

        // R4: quiet source, burst then quiet, gap one short of the window.
        normal_recovery(0, 0, 0, QUIET);
        for (int i = 0; i < 4; i++) send_word(DW'(8'h30 + i));
        normal_recovery(5, 0, 0, 1 + 5 + QUIET);
        for (int i = 0; i < 4; i++) send_word(DW'(8'h40 + i));
        normal_recovery(2, QUIET - 1, 1, 1 + 2 + (QUIET - 1) + 1 + QUIET);
        // R9: fresh stream intact from its first word.
        for (int i = 0; i < 8; i++) send_word(DW'(8'h50 + i));

        // R7: engine stays in fault; reset reissued after the timeout.
        stuck = 1'b1;
        fault_and_flush(0, 0, 0, QUIET, flen);
        measure_pulse(rlen);
        chk(rlen == RSTC, "R5 first pulse length", rlen, RSTC);
        gap = 0;
        while (!eng_reset && gap < 1000) begin gap++; step_cycle(); end
        chk(gap == TMO, "R7 wait before re-reset", gap, TMO);
        stuck = 1'b0;
        measure_pulse(rlen);
        chk(rlen == RSTC, "R7 second pulse length", rlen, RSTC);
        step_cycle();
        chk(!recovering, "R7 idle after second reset", int'(recovering), 0);
        for (int i = 0; i < 3; i++) send_word(DW'(8'h60 + i));

        // R8: block reset in the middle of the engine reset pulse.
        fault_and_flush(0, 0, 0, QUIET, flen);
        @(negedge clk); rst_n = 1'b0; #8;
        step_cycle();
        chk(!eng_reset && !recovering, "R8 reset mid-pulse", int'(eng_reset), 0);
        @(negedge clk); rst_n = 1'b1;
        normal_recovery(0, 0, 0, QUIET);
        for (int i = 0; i < 3; i++) send_word(DW'(8'h70 + i));
        repeat (4) step_cycle();
        chk(expq.size() == 0, "R9 all expected words delivered", expq.size(), 0);

        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 150000);
        if (!done_flag) begin
            done_flag = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule